// File: doc/BRIEF.md
# Indexed Integer Dot-Product Accumulator

This unit handles one 256-bit vector per cycle. It adds a sum of four integer products to every accumulator lane. Element size is selected per operation:

- **Byte elements:** four 8-bit products feed each 32-bit lane.
- **Halfword elements:** four 16-bit products feed each 64-bit lane.

One signedness control applies to both source vectors. Accumulation wraps modulo the lane width and never saturates.

In indexed mode, the second source is not consumed lane by lane. Within each 128-bit segment, an index picks one four-element group of the second source. That group is shared by every accumulator lane in the segment. All operands of a segment are read from the input vectors in the same cycle, so no lane result can disturb a neighbour's inputs. The active operand size is given in 64-bit units. Lanes at and above that size leave the block as zero.

Top module: `dot_acc_unit`

## Requirements
- R1: In byte mode (`half_i`=0), 32-bit lane i of `res_o` equals `acc_i` lane i plus the sum over k=0..3 of byte `n_i`[4i+k] times byte `m_i`[4i+k]. Byte j occupies bits [8j+7:8j].
- R2: In halfword mode (`half_i`=1), 64-bit lane i equals `acc_i` lane i plus the sum over k=0..3 of halfword `n_i`[4i+k] times halfword `m_i`[4i+k]. Halfword j occupies bits [16j+15:16j].
- R3: With `signed_i`=1, every element of both sources is sign-extended before multiplying. With `signed_i`=0, every element is zero-extended.
- R4: In byte indexed mode (`indexed_i`=1), every lane in 128-bit segment s uses as its second operand the 32-bit group at bits [s*128 + `index_i`*32 +: 32] of `m_i`.
- R5: In halfword indexed mode, every lane in segment s uses the 64-bit group at bits [s*128 + `index_i`[0]*64 +: 64] of `m_i`. `index_i`[1] has no effect.
- R6: `opr_dw_i` gives the active size in 64-bit units. The legal values are 1, 2 and 4. Every `res_o` bit at position opr_dw_i*64 or above is zero.
- R7: Lane sums wrap modulo 2^32 in byte mode and modulo 2^64 in halfword mode, with no saturation.
- R8: `valid_o` and `res_o` update one clock after an accepted `valid_i`. While `valid_i` is low, `res_o` holds its value and `valid_o` is low.
- R9: After reset, `valid_o` is 0 and `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request for this cycle |
| half_i | input | 1 | 0: byte elements into 32-bit lanes; 1: halfwords into 64-bit lanes |
| signed_i | input | 1 | 1: signed elements; 0: unsigned elements |
| indexed_i | input | 1 | 1: broadcast one group per 128-bit segment |
| index_i | input | 2 | Group select within a segment (bit 0 only in halfword mode) |
| opr_dw_i | input | 3 | Active operand size in 64-bit units |
| acc_i | input | 256 | Accumulator vector |
| n_i | input | 256 | First source vector |
| m_i | input | 256 | Second source vector |
| valid_o | output | 1 | Result valid |
| res_o | output | 256 | Result vector |

## Verification
Every result is due exactly one clock edge after the cycle in which `valid_i` is high, because the datapath has a single output register. The bench changes inputs on the falling edge and samples `res_o` shortly after the next rising edge. A result is therefore compared only in the cycle it first appears. The hold check lowers `valid_i` and changes the sources, then samples again two edges later. A stale or recomputed output shows up there as a change.

// File: rtl/dot_pkg.sv
package dot_pkg;
  localparam int unsigned ELEMS_PER_LANE = 4;
  localparam int unsigned BYTE_EW = 8;
  localparam int unsigned HALF_EW = 16;
endpackage

// File: rtl/dot_lane.sv
module dot_lane #(
  parameter int unsigned EW = 8,
  parameter int unsigned LW = 32
) (
  input  logic          sgn_i,
  input  logic [LW-1:0] acc_i,
  input  logic [4*EW-1:0] n_i,
  input  logic [4*EW-1:0] m_i,
  output logic [LW-1:0] sum_o
);
  localparam int unsigned PW = 2*EW + 2;

  logic signed [EW:0] ne [4];
  logic signed [EW:0] me [4];
  logic signed [PW-1:0] prod [4];

  always_comb begin
    sum_o = acc_i;
    for (int k = 0; k < 4; k++) begin
      ne[k] = {sgn_i & n_i[k*EW+EW-1], n_i[k*EW +: EW]};
      me[k] = {sgn_i & m_i[k*EW+EW-1], m_i[k*EW +: EW]};
      prod[k] = ne[k] * me[k];
      sum_o = sum_o + {{(LW-PW){prod[k][PW-1]}}, prod[k]};
    end
  end

  // R1 R2: zero second operand leaves accumulator untouched
  always_comb begin
    if (m_i == '0) a_r1_zero_operand: assert (sum_o == acc_i);
  end
endmodule

// File: rtl/dot_bcast_sel.sv
module dot_bcast_sel #(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned SEG_W = 128,
  parameter int unsigned GW    = 32,
  parameter int unsigned IDX_W = $clog2(SEG_W/GW)
) (
  input  logic             idx_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VEC_W-1:0] m_i,
  output logic [VEC_W-1:0] m_o
);
  localparam int unsigned LANES = VEC_W / GW;
  localparam int unsigned LPS   = SEG_W / GW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned SEG_BASE = (l / LPS) * SEG_W;
    logic [GW-1:0] grp;
    assign grp = m_i[SEG_BASE + idx_i*GW +: GW];
    assign m_o[l*GW +: GW] = idx_en_i ? grp : m_i[l*GW +: GW];
  end
endmodule

// File: rtl/dot_acc_unit.sv
module dot_acc_unit
  import dot_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned SEG_W = 128,
  localparam int unsigned DW_CNT = VEC_W / 64,
  localparam int unsigned DW_W   = $clog2(DW_CNT) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             half_i,
  input  logic             signed_i,
  input  logic             indexed_i,
  input  logic [1:0]       index_i,
  input  logic [DW_W-1:0]  opr_dw_i,
  input  logic [VEC_W-1:0] acc_i,
  input  logic [VEC_W-1:0] n_i,
  input  logic [VEC_W-1:0] m_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned BLW = ELEMS_PER_LANE * BYTE_EW;
  localparam int unsigned HLW = ELEMS_PER_LANE * HALF_EW;
  localparam int unsigned B_LANES = VEC_W / BLW;
  localparam int unsigned H_LANES = VEC_W / HLW;
  localparam int unsigned B_IDX_W = $clog2(SEG_W / BLW);
  localparam int unsigned H_IDX_W = $clog2(SEG_W / HLW);

  logic [VEC_W-1:0] m_byte, m_half, sum_byte, sum_half, sum_sel, keep, next_res;

  dot_bcast_sel #(.VEC_W(VEC_W), .SEG_W(SEG_W), .GW(BLW), .IDX_W(B_IDX_W)) u_sel_byte (
    .idx_en_i (indexed_i),
    .idx_i    (index_i[B_IDX_W-1:0]),
    .m_i      (m_i),
    .m_o      (m_byte)
  );

  dot_bcast_sel #(.VEC_W(VEC_W), .SEG_W(SEG_W), .GW(HLW), .IDX_W(H_IDX_W)) u_sel_half (
    .idx_en_i (indexed_i),
    .idx_i    (index_i[H_IDX_W-1:0]),
    .m_i      (m_i),
    .m_o      (m_half)
  );

  for (genvar l = 0; l < B_LANES; l++) begin : g_byte
    dot_lane #(.EW(BYTE_EW), .LW(BLW)) u_lane (
      .sgn_i (signed_i),
      .acc_i (acc_i[l*BLW +: BLW]),
      .n_i   (n_i[l*BLW +: BLW]),
      .m_i   (m_byte[l*BLW +: BLW]),
      .sum_o (sum_byte[l*BLW +: BLW])
    );
  end

  for (genvar l = 0; l < H_LANES; l++) begin : g_half
    dot_lane #(.EW(HALF_EW), .LW(HLW)) u_lane (
      .sgn_i (signed_i),
      .acc_i (acc_i[l*HLW +: HLW]),
      .n_i   (n_i[l*HLW +: HLW]),
      .m_i   (m_half[l*HLW +: HLW]),
      .sum_o (sum_half[l*HLW +: HLW])
    );
  end

  // tail mask in 64-bit units
  for (genvar d = 0; d < DW_CNT; d++) begin : g_keep
    assign keep[d*64 +: 64] = {64{opr_dw_i > DW_W'(d)}};
  end

  assign sum_sel  = half_i ? sum_half : sum_byte;
  assign next_res = sum_sel & keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= next_res;
    end
  end

  function automatic logic [VEC_W-1:0] tail_of(input logic [DW_W-1:0] dw);
    logic [VEC_W-1:0] t;
    for (int d = 0; d < DW_CNT; d++) t[d*64 +: 64] = (dw > DW_W'(d)) ? '0 : '1;
    return t;
  endfunction

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o)));
  a_r6_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((res_o & tail_of($past(opr_dw_i))) == '0));
  a_r6_legal_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (opr_dw_i == 1 || opr_dw_i == 2 || opr_dw_i == 4));
endmodule

// File: tb/dot_acc_unit_tb_top.sv
module dot_acc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic clk = 0, rst_n = 0;
  logic valid = 0, half = 0, sgn = 0, idx_en = 0;
  logic [1:0] idx = 0;
  logic [2:0] dw = 4;
  logic [255:0] acc = 0, n = 0, m = 0;
  logic valid_o;
  logic [255:0] res;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dot_acc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .half_i(half), .signed_i(sgn),
    .indexed_i(idx_en), .index_i(idx), .opr_dw_i(dw), .acc_i(acc), .n_i(n), .m_i(m),
    .valid_o(valid_o), .res_o(res)
  );

  // {half, signed, indexed, index[1:0], dw[2:0], seed[15:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0,1'b0,1'b0,2'd0,3'd4,16'h1234},  // R1 unsigned byte
    {1'b0,1'b1,1'b0,2'd0,3'd4,16'h0bad},  // R1 R3 signed byte
    {1'b1,1'b0,1'b0,2'd0,3'd4,16'h7777},  // R2 unsigned half
    {1'b1,1'b1,1'b0,2'd0,3'd4,16'h5a5a},  // R2 R3 signed half
    {1'b0,1'b1,1'b1,2'd3,3'd4,16'h0042},  // R4 byte idx 3
    {1'b0,1'b0,1'b1,2'd1,3'd2,16'h0099},  // R4 R6 byte idx 1, 16 bytes
    {1'b1,1'b1,1'b1,2'd1,3'd4,16'h3c3c},  // R5 half idx 1
    {1'b1,1'b0,1'b1,2'd0,3'd2,16'h1111},  // R5 R6 half idx 0
    {1'b0,1'b1,1'b1,2'd2,3'd1,16'hbeef},  // R4 R6 8-byte special
    {1'b1,1'b1,1'b0,2'd0,3'd1,16'hcafe}   // R2 R6 8-byte half
  };

  function automatic logic [255:0] gen(input logic [15:0] seed, input int salt);
    logic [31:0] x = {seed, 16'h9e37} ^ 32'(salt * 32'h61c88647);
    logic [255:0] v;
    for (int w = 0; w < 8; w++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      v[w*32 +: 32] = x ^ (x >> 13);
    end
    return v;
  endfunction

  function automatic logic [63:0] ext(input logic [15:0] e, input bit h, input bit s);
    if (h) return s ? {{48{e[15]}}, e} : {48'd0, e};
    return s ? {{56{e[7]}}, e[7:0]} : {56'd0, e[7:0]};
  endfunction

  function automatic logic [255:0] model(input bit h, input bit s, input bit ie,
      input logic [1:0] ix, input logic [2:0] d, input logic [255:0] a,
      input logic [255:0] nn, input logic [255:0] mm);
    logic [255:0] r = '0;
    int lw = h ? 64 : 32;
    int ew = h ? 16 : 8;
    int lps = 128 / lw;
    for (int l = 0; l < 256 / lw; l++) begin
      logic [63:0] sum = h ? a[l*64 +: 64] : {32'd0, a[l*32 +: 32]};
      int mb = ie ? ((l / lps) * 128 + (h ? ix[0] : ix) * lw) : l * lw;
      for (int k = 0; k < 4; k++)
        sum = sum + ext(16'(nn >> (l*lw + k*ew)), h, s) * ext(16'(mm >> (mb + k*ew)), h, s);
      if (h) r[l*64 +: 64] = sum; else r[l*32 +: 32] = sum[31:0];
    end
    for (int q = 0; q < 4; q++) if (q >= d) r[q*64 +: 64] = '0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag);
    @(negedge clk);
    valid = 1;
    @(posedge clk); #1;
    check({tag, " valid"}, {255'd0, valid_o}, 256'd1);
    check(tag, res, model(half, sgn, idx_en, idx, dw, acc, n, m));
    @(negedge clk);
    valid = 0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [255:0] held, r_i0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset res", res, '0);
    check("R9 reset valid", {255'd0, valid_o}, '0);
    @(negedge clk);
    rst_n = 1;

    for (int v = 0; v < NVEC; v++) begin
      {half, sgn, idx_en, idx, dw} = VEC[v][23:16];
      acc = gen(VEC[v][15:0], 1);
      n   = gen(VEC[v][15:0], 2);
      m   = gen(VEC[v][15:0], 3);
      run($sformatf("R1 R2 R3 R4 R5 R6 vec %0d", v));
    end

    // R3: all-ones elements, signed gives +1 per product, unsigned 255*255
    half = 0; idx_en = 0; dw = 4; acc = '0; n = '1; m = '1;
    sgn = 1; run("R3 signed -1*-1");
    check("R3 signed lane0", {224'd0, res[31:0]}, 256'd4);
    sgn = 0; run("R3 unsigned 255*255");
    check("R3 unsigned lane0", {224'd0, res[31:0]}, 256'd260100);

    // R7: wrap in byte lanes and halfword lanes
    sgn = 0; n = '0; m = '0;
    for (int l = 0; l < 8; l++) begin acc[l*32 +: 32] = 32'hffff_ffff; n[l*32] = 1'b1; m[l*32] = 1'b1; end
    run("R7 byte wrap");
    check("R7 byte lane7 zero", {224'd0, res[255:224]}, '0);
    half = 1; acc = '1; n = '0; m = '0;
    for (int l = 0; l < 4; l++) begin n[l*64] = 1'b1; m[l*64] = 1'b1; end
    run("R7 half wrap");
    check("R7 half lane3 zero", {192'd0, res[255:192]}, '0);

    // R5: index bit 1 ignored in halfword indexed mode
    half = 1; sgn = 1; idx_en = 1; dw = 4;
    acc = gen(16'h4321, 1); n = gen(16'h4321, 2); m = gen(16'h4321, 3);
    idx = 2'd0; run("R5 idx 0");
    r_i0 = res;
    idx = 2'd2; run("R5 idx 2");
    check("R5 idx bit1 ignored", res, r_i0);

    // R8: hold while valid low
    held = res;
    @(negedge clk);
    n = ~n; m = ~m; acc = ~acc;
    @(posedge clk); @(posedge clk); #1;
    check("R8 hold res", res, held);
    check("R8 valid low", {255'd0, valid_o}, '0);

    summary();
  end
endmodule